// File: doc/BRIEF.md
# Ramped Stereo Attenuator with Output Mode Matrix

This block scales a pair of parallel audio samples by per-channel 8-bit gain counters and routes them through a four-way source selector on each output. Software loads a 24-bit command through a three-wire serial port: a shift clock, a data line and a latch line. All three are sampled in the system clock domain. The command sets the two attenuation targets, the routing code of each output, a link flag that makes the left target drive both channels, and a deemphasis enable that is passed on to a filter outside this block.

The gain counters never jump. On every step tick, each one moves by one count toward its target. A step tick comes once every `STEP_FRAMES` frame strobes. Selecting mute for an output drives that channel's target to zero, which gives a soft fade to silence. Leaving mute ramps the gain back up. After reset the outputs are held at zero until the ninth frame strobe.

Top module: `gain_ramp_router`

## Requirements
- R1: Serial command bits are captured on each rising edge of `ctl_clk`, one bit per edge. The first bit sent lands in command bit 0. Once all 24 bits are in, the command reads: bits 7:0 left attenuation, bits 15:8 right attenuation, bit 16 PL0, bit 17 PL1, bit 18 PL2, bit 19 PL3, bit 20 deemphasis, bit 21 link. The command takes effect only on a rising edge of `ctl_latch`.
- R2: `deemph_en` presents the deemphasis bit of the last latched command.
- R3: Each output equals (source × gain + 128) >>> 8, computed on signed values. The gain is the channel's counter value, 0 to 255. A gain of 0 gives an output of 0.
- R4: A gain counter changes only on a step tick, which comes once every `STEP_FRAMES` frame strobes. On a step tick it moves exactly one count toward its target.
- R5: When the link bit is 1, the left attenuation value is the target of both channels.
- R6: The left output source is chosen by the code {PL0,PL1} and the right output source by the code {PL2,PL3}. In both codes, 01 selects the right input, 10 selects the left input and 11 selects the average.
- R7: Code 00 is mute. It keeps the channel's own input as the source and sets that channel's target to 0. When the code changes away from 00, the counter ramps back up toward the attenuation value.
- R8: After reset the left code is 10 and the right code is 01 (straight stereo), deemphasis is 0, the link bit is 0, and both gain counters are 255.
- R9: Both outputs are held at 0 after reset until the ninth frame strobe has been seen.
- R10: The average is the 17-bit signed sum of the left and right inputs, shifted right by one bit arithmetically.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_clk | input | 1 | Serial command shift clock, sampled on `clk` |
| ctl_dat | input | 1 | Serial command data |
| ctl_latch | input | 1 | Command latch line; its rising edge applies the command |
| frame_stb | input | 1 | One-cycle pulse, once per sample frame |
| smp_l | input | 16 | Left input sample, two's complement |
| smp_r | input | 16 | Right input sample, two's complement |
| out_l | output | 16 | Routed and scaled left output |
| out_r | output | 16 | Routed and scaled right output |
| deemph_en | output | 1 | Deemphasis enable for the downstream filter |

## Verification
The bench sets `STEP_FRAMES` to 1, with a frame strobe every four clocks. At that setting a full fade from 255 to 0, or back, takes about a thousand clocks. Several complete ramps therefore fit in one run: downward, upward and toward a linked target. The bench keeps `UNMUTE_FRAMES` at 9, so the startup hold is covered as specified. Full-scale and random samples drive the rounding and averaging arithmetic at both ends of the signed range.

// File: rtl/gainramp_pkg.sv
package gainramp_pkg;
  localparam int SMP_W  = 16;
  localparam int ATT_W  = 8;
  localparam int CMD_W  = 24;
  localparam int PROD_W = SMP_W + ATT_W + 1;

  typedef enum logic [1:0] {
    SRC_MUTE  = 2'b00,
    SRC_RIGHT = 2'b01,
    SRC_LEFT  = 2'b10,
    SRC_MIX   = 2'b11
  } src_e;

  // average of two samples: widened sum, then divide by two with sign kept
  function automatic logic signed [SMP_W-1:0] mix_avg(input logic signed [SMP_W-1:0] a,
                                                      input logic signed [SMP_W-1:0] b);
    logic signed [SMP_W:0] s;
    s = {a[SMP_W-1], a} + {b[SMP_W-1], b};
    return s[SMP_W:1];
  endfunction

  // apply gain: product with rounding constant, keep bits above the fraction
  function automatic logic signed [SMP_W-1:0] scale_gain(input logic signed [SMP_W-1:0] s,
                                                         input logic [ATT_W-1:0] g);
    logic signed [PROD_W-1:0] p;
    p = s * $signed({1'b0, g});
    p = p + PROD_W'(1 << (ATT_W - 1));
    return p[SMP_W+ATT_W-1:ATT_W];
  endfunction

  // pick a source; mute keeps the channel's own input while the gain fades
  function automatic logic signed [SMP_W-1:0] pick_src(input src_e code,
                                                       input logic signed [SMP_W-1:0] l,
                                                       input logic signed [SMP_W-1:0] r,
                                                       input logic signed [SMP_W-1:0] own);
    case (code)
      SRC_RIGHT: return r;
      SRC_LEFT:  return l;
      SRC_MIX:   return mix_avg(l, r);
      default:   return own;
    endcase
  endfunction
endpackage

// File: rtl/ramp_ctl_port.sv
module ramp_ctl_port import gainramp_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_clk,
  input  logic             ctl_dat,
  input  logic             ctl_latch,
  output logic [ATT_W-1:0] att_l,
  output logic [ATT_W-1:0] att_r,
  output logic [3:0]       pl,
  output logic             dem,
  output logic             atc
);
  localparam int PL_POS  = 2 * ATT_W;
  localparam int DEM_POS = PL_POS + 4;
  localparam int ATC_POS = DEM_POS + 1;

  logic [CMD_W-1:0] shreg;
  logic clk_q, lat_q;
  logic shift_edge, lat_edge;

  assign shift_edge = ctl_clk & ~clk_q;
  assign lat_edge   = ctl_latch & ~lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_q <= 1'b0;
      lat_q <= 1'b0;
      shreg <= '0;
      att_l <= '1;
      att_r <= '1;
      pl    <= 4'b1001;
      dem   <= 1'b0;
      atc   <= 1'b0;
    end else begin
      clk_q <= ctl_clk;
      lat_q <= ctl_latch;
      if (shift_edge) shreg <= {ctl_dat, shreg[CMD_W-1:1]};
      if (lat_edge) begin
        att_l <= shreg[ATT_W-1:0];
        att_r <= shreg[2*ATT_W-1:ATT_W];
        pl    <= shreg[PL_POS+3:PL_POS];
        dem   <= shreg[DEM_POS];
        atc   <= shreg[ATC_POS];
      end
    end
  end

  AST_DEM_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    lat_edge |=> dem == $past(shreg[DEM_POS])); // R2
endmodule

// File: rtl/gain_ramp.sv
module gain_ramp import gainramp_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_tick,
  input  logic             mute_req,
  input  logic [ATT_W-1:0] target_att,
  output logic [ATT_W-1:0] gain
);
  logic [ATT_W-1:0] tgt;
  assign tgt = mute_req ? '0 : target_att;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gain <= '1;
    else if (step_tick) begin
      if (gain < tgt)      gain <= gain + 1'b1;
      else if (gain > tgt) gain <= gain - 1'b1;
    end
  end

  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (gain == $past(gain)) ||
             ({1'b0, gain} == {1'b0, $past(gain)} + 9'd1) ||
             ({1'b0, gain} + 9'd1 == {1'b0, $past(gain)})); // R4
  AST_HOLD_OFF_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !step_tick |=> $stable(gain)); // R4
  AST_MUTE_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (step_tick && mute_req && gain != '0) |=> gain < $past(gain)); // R7
endmodule

// File: rtl/gain_ramp_router.sv
module gain_ramp_router import gainramp_pkg::*; #(
  parameter int STEP_FRAMES   = 4,
  parameter int UNMUTE_FRAMES = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_clk,
  input  logic             ctl_dat,
  input  logic             ctl_latch,
  input  logic             frame_stb,
  input  logic [SMP_W-1:0] smp_l,
  input  logic [SMP_W-1:0] smp_r,
  output logic [SMP_W-1:0] out_l,
  output logic [SMP_W-1:0] out_r,
  output logic             deemph_en
);
  localparam int PW = (STEP_FRAMES > 1) ? $clog2(STEP_FRAMES) : 1;
  localparam int UW = $clog2(UNMUTE_FRAMES + 1);

  logic [ATT_W-1:0] att_l, att_r;
  logic [3:0] pl;
  logic atc;
  logic [PW-1:0] presc;
  logic [UW-1:0] up_cnt;
  logic step_tick, live;
  logic [ATT_W-1:0] gain_w [2];
  logic signed [SMP_W-1:0] src_w [2];

  ramp_ctl_port u_ctl (
    .clk(clk), .rst_n(rst_n), .ctl_clk(ctl_clk), .ctl_dat(ctl_dat), .ctl_latch(ctl_latch),
    .att_l(att_l), .att_r(att_r), .pl(pl), .dem(deemph_en), .atc(atc)
  );

  assign step_tick = frame_stb && (presc == PW'(STEP_FRAMES - 1));
  assign live      = (up_cnt == UW'(UNMUTE_FRAMES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc  <= '0;
      up_cnt <= '0;
    end else begin
      if (step_tick)      presc <= '0;
      else if (frame_stb) presc <= presc + 1'b1;
      if (frame_stb && !live) up_cnt <= up_cnt + 1'b1;
    end
  end

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    src_e code;
    logic [ATT_W-1:0] tgt_att;
    if (ch == 0) begin : g_left
      assign code    = src_e'({pl[0], pl[1]});
      assign tgt_att = att_l;
      assign src_w[ch] = pick_src(code, $signed(smp_l), $signed(smp_r), $signed(smp_l));
    end else begin : g_right
      assign code    = src_e'({pl[2], pl[3]});
      assign tgt_att = atc ? att_l : att_r;
      assign src_w[ch] = pick_src(code, $signed(smp_l), $signed(smp_r), $signed(smp_r));
    end
    gain_ramp u_ramp (
      .clk(clk), .rst_n(rst_n), .step_tick(step_tick),
      .mute_req(code == SRC_MUTE), .target_att(tgt_att), .gain(gain_w[ch])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_l <= '0;
      out_r <= '0;
    end else begin
      out_l <= live ? scale_gain(src_w[0], gain_w[0]) : '0;
      out_r <= live ? scale_gain(src_w[1], gain_w[1]) : '0;
    end
  end

  AST_ZERO_GAIN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_w[0] == '0) |=> out_l == '0); // R3
  AST_STARTUP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (up_cnt == '0) |=> (out_l == '0 && out_r == '0)); // R9
endmodule

// File: tb/sim_gain_ramp_router.sv
module sim_gain_ramp_router;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_clk = 1'b0, ctl_dat = 1'b0, ctl_latch = 1'b0, frame_stb = 1'b0;
  logic [15:0] smp_l = '0, smp_r = '0;
  logic [15:0] out_l, out_r;
  logic deemph_en;

  int checks = 0, fails = 0;
  string tag = "R8";
  int pattern = 0;  // 0 fixed, 1 random, 2 extremes
  int fix_l = 1000, fix_r = -2000;
  bit finished = 0;

  always #2.5 clk = ~clk;

  gain_ramp_router #(.STEP_FRAMES(1), .UNMUTE_FRAMES(9)) u0 (
    .clk(clk), .rst_n(rst_n), .ctl_clk(ctl_clk), .ctl_dat(ctl_dat), .ctl_latch(ctl_latch),
    .frame_stb(frame_stb), .smp_l(smp_l), .smp_r(smp_r),
    .out_l(out_l), .out_r(out_r), .deemph_en(deemph_en)
  );

  // ---------------- behavioural reference ----------------
  bit [23:0] m_sr;
  bit m_pclk, m_plat, m_dem, m_atc;
  bit [3:0] m_pl;
  int m_attl, m_attr, m_gl, m_gr, m_frames, m_expl, m_expr;

  function automatic int scl(int s, int g);
    return (s * g + 128) >>> 8;
  endfunction

  function automatic int srcsel(int code, int l, int r, int own);
    if (code == 1) return r;
    if (code == 2) return l;
    if (code == 3) return (l + r) >>> 1;
    return own;
  endfunction

  function automatic int stepto(int g, int t);
    if (g < t) return g + 1;
    if (g > t) return g - 1;
    return g;
  endfunction

  task automatic m_reset();
    m_sr = 0; m_pclk = 0; m_plat = 0; m_dem = 0; m_atc = 0; m_pl = 4'b1001;
    m_attl = 255; m_attr = 255; m_gl = 255; m_gr = 255; m_frames = 0;
    m_expl = 0; m_expr = 0;
  endtask

  initial m_reset();

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else begin
      int l, r, cl, cr, tl, tr;
      l = $signed(smp_l); r = $signed(smp_r);
      cl = {m_pl[0], m_pl[1]}; cr = {m_pl[2], m_pl[3]};
      m_expl = (m_frames >= 9) ? scl(srcsel(cl, l, r, l), m_gl) : 0;
      m_expr = (m_frames >= 9) ? scl(srcsel(cr, l, r, r), m_gr) : 0;
      tl = (cl == 0) ? 0 : m_attl;
      tr = (cr == 0) ? 0 : (m_atc ? m_attl : m_attr);
      if (frame_stb) begin
        m_gl = stepto(m_gl, tl);
        m_gr = stepto(m_gr, tr);
        if (m_frames < 9) m_frames++;
      end
      if (ctl_latch && !m_plat) begin
        m_attl = m_sr[7:0]; m_attr = m_sr[15:8]; m_pl = m_sr[19:16];
        m_dem = m_sr[20]; m_atc = m_sr[21];
      end
      if (ctl_clk && !m_pclk) m_sr = {ctl_dat, m_sr[23:1]};
      m_pclk = ctl_clk; m_plat = ctl_latch;
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check({tag, " out_l"}, $signed(out_l), m_expl);
      check({tag, " out_r"}, $signed(out_r), m_expr);
      check("R2 deemph", deemph_en, m_dem);
    end
  end

  // stimulus: frame strobe and samples
  int cyc = 0;
  always @(negedge clk) begin
    cyc++;
    frame_stb <= (cyc % 4 == 0);
    if (pattern == 0) begin smp_l <= 16'(fix_l); smp_r <= 16'(fix_r); end
    else if (pattern == 1) begin smp_l <= 16'($urandom); smp_r <= 16'($urandom); end
    else begin
      smp_l <= (cyc % 2 == 0) ? 16'h8000 : 16'h7fff;
      smp_r <= (cyc % 3 == 0) ? 16'h7fff : 16'h8000;
    end
  end

  function automatic bit [23:0] mk(int al, int ar, bit p0, bit p1, bit p2, bit p3, bit d, bit a);
    return {2'b00, a, d, p3, p2, p1, p0, 8'(ar), 8'(al)};
  endfunction

  task automatic waitc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(bit [23:0] w);
    for (int i = 0; i < 24; i++) begin
      ctl_dat = w[i]; ctl_clk = 1'b0; waitc(2);
      ctl_clk = 1'b1; waitc(2);
    end
    ctl_clk = 1'b0; waitc(2);
    ctl_latch = 1'b1; waitc(2);
    ctl_latch = 1'b0; waitc(2);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    waitc(4);
    check("R8 reset out_l", $signed(out_l), 0);
    check("R8 reset out_r", $signed(out_r), 0);
    check("R8 reset deemph", deemph_en, 0);
    rst_n = 1'b1;
    tag = "R9";
    waitc(20);
    check("R9 held before ninth frame", $signed(out_l), 0);
    waitc(30);
    tag = "R8";
    check("R3 R8 stereo full gain left", $signed(out_l), 996);
    check("R3 R8 stereo full gain right", $signed(out_r), -1992);

    tag = "R1";
    send(mk(128, 255, 1, 0, 0, 1, 1, 0));
    check("R2 deemph set", deemph_en, 1);
    tag = "R4";
    waitc(1200);
    check("R1 R4 left atten 128", $signed(out_l), 500);

    tag = "R5";
    send(mk(64, 200, 1, 0, 0, 1, 0, 1));
    waitc(1200);
    check("R5 linked right", $signed(out_r), -500);

    tag = "R6";
    send(mk(255, 255, 0, 1, 1, 0, 0, 0));
    waitc(1200);
    check("R6 swapped left", $signed(out_l), -1992);
    check("R6 swapped right", $signed(out_r), 996);

    tag = "R10";
    send(mk(255, 255, 1, 1, 1, 1, 0, 0));
    waitc(10);
    check("R10 average left", $signed(out_l), -498);
    pattern = 2;
    waitc(200);
    pattern = 1;
    waitc(400);

    tag = "R7";
    send(mk(255, 255, 0, 0, 0, 0, 0, 0));
    waitc(1200);
    check("R7 muted left", $signed(out_l), 0);
    check("R7 muted right", $signed(out_r), 0);
    send(mk(255, 255, 1, 0, 0, 1, 0, 0));
    waitc(1200);

    tag = "R3";
    pattern = 2;
    waitc(300);
    finish_run();
  end
endmodule